// File: doc/BRIEF.md
# Counter Interrupt Cause and Pending Tracker

This block sits next to a hardware event counter and turns the counter's single-cycle event pulses into one serviced interrupt. There are four event kinds: overflow, underflow, high threshold reached and low threshold reached. When an event is accepted, the block records which kind of event caused it in a one-hot cause register. It also marks the interrupt as pending. If a further event is accepted before the processor starts servicing the first one, the block raises a lost flag.

The processor drives a few plain control pulses:
- a service-start strobe, which retires the pending interrupt;
- a clear command, which drops both pending and lost;
- a lost-clear write, which drops lost only;
- enable-set and enable-clear commands;
- a first-configuration pulse, which switches the interrupt enable on.

The interrupt request is the pending flag qualified by enable. No data stream passes through the block, so every pin is a level or a pulse with no valid/ready handshake and no back-pressure. Every status output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `irq_cause_tracker`

## Requirements
- R1: While rst_n is low, and on the first edge after reset, cause_o, pending_o, lost_o, enable_o and irq_o are all zero.
- R2: An accepted event loads cause_o with exactly one set bit and clears the other bits. When no event is accepted, cause_o holds its value. The bit meanings are: bit 0 overflow, bit 1 underflow, bit 2 high reached, bit 3 low reached.
- R3: When several event bits are high in one accepted cycle, the lowest-numbered bit is recorded. The order is overflow, then underflow, then high, then low.
- R4: An event is accepted when any evt_i bit is high while enable_o is 1. An accepted event sets pending_o on the next edge.
- R5: A svc_start_i pulse clears pending_o, except when an event is accepted in the same cycle, in which case pending_o stays 1.
- R6: An accepted event that arrives while pending_o is 1 sets lost_o, unless svc_start_i, clr_cmd_i or lost_clr_i is high in the same cycle.
- R7: lost_clr_i or clr_cmd_i clears lost_o, and this takes precedence over a loss in the same cycle. lost_clr_i leaves pending_o untouched.
- R8: clr_cmd_i clears pending_o, and this takes precedence over an event accepted in the same cycle. cause_o still updates from such an event.
- R9: cfg_first_i or en_set_i sets enable_o. en_clr_i clears enable_o. When both a set and a clear arrive together, the set wins.
- R10: While enable_o is 0, events leave cause_o, pending_o and lost_o unchanged.
- R11: irq_o is 1 exactly when pending_o and enable_o are both 1. A pending interrupt survives a disable and requests again once the block is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_EV | Event pulses: bit 0 overflow, bit 1 underflow, bit 2 high reached, bit 3 low reached |
| cfg_first_i | input | 1 | First-configuration pulse; switches enable on |
| en_set_i | input | 1 | Enable command |
| en_clr_i | input | 1 | Disable command |
| svc_start_i | input | 1 | Service routine start strobe |
| clr_cmd_i | input | 1 | Clears pending and lost |
| lost_clr_i | input | 1 | Clears lost only |
| cause_o | output | N_EV | One-hot latched cause |
| pending_o | output | 1 | Interrupt awaiting service |
| lost_o | output | 1 | An interrupt was dropped |
| enable_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default N_EV of 4. At that width, every one of the sixteen event combinations can be applied in a single cycle, so the full priority chain is exercised, including all-bits-high. The directed sequences cover:
- a service strobe arriving together with a new event;
- a clear command racing an event;
- an event arriving while disabled;
- a simultaneous enable set and clear.

A long pseudo-random run then compares all outputs on every cycle against a behavioural model.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int unsigned EV_OVF  = 0;
  localparam int unsigned EV_UNF  = 1;
  localparam int unsigned EV_HI   = 2;
  localparam int unsigned EV_LO   = 3;
  localparam int unsigned N_CAUSE = 4;

  typedef struct packed {
    logic pending;
    logic lost;
  } svc_state_t;
endpackage

// File: rtl/irq_cause_pick.sv
module irq_cause_pick #(
  parameter int unsigned N_EV = irq_trk_pkg::N_CAUSE
) (
  input  logic [N_EV-1:0] req_i,
  output logic [N_EV-1:0] grant_o,
  output logic            any_o
);
  logic [N_EV:0] seen;
  assign seen[0] = 1'b0;

  // lowest index wins; seen[i] marks any request below bit i
  for (genvar i = 0; i < N_EV; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N_EV];
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned N_EV = irq_trk_pkg::N_CAUSE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [N_EV-1:0] grant_i,
  output logic [N_EV-1:0] cause_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause_o <= '0;
    else if (load_i) cause_o <= grant_i;
  end

  // R2: cause register never holds more than one bit
  p_cause_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_o));

  // R2: a load leaves exactly one bit set
  p_cause_loaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> $countones(cause_o) == 1);

  // R2: no load means the cause is held
  p_cause_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cause_o));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_first_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic enable_o
);
  logic turn_on;
  assign turn_on = cfg_first_i | en_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        enable_o <= 1'b0;
    else if (turn_on)  enable_o <= 1'b1;
    else if (en_clr_i) enable_o <= 1'b0;
  end

  // R9: set commands win
  p_en_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_first_i || en_set_i) |=> enable_o);

  // R9: a lone clear disables
  p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_i && !cfg_first_i && !en_set_i) |=> !enable_o);
endmodule

// File: rtl/irq_pend_lost.sv
module irq_pend_lost (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic svc_start_i,
  input  logic clr_cmd_i,
  input  logic lost_clr_i,
  output logic pending_o,
  output logic lost_o
);
  import irq_trk_pkg::*;

  svc_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr_cmd_i)        st_d.pending = 1'b0;
    else if (accept_i)    st_d.pending = 1'b1;
    else if (svc_start_i) st_d.pending = 1'b0;

    if (clr_cmd_i || lost_clr_i)
      st_d.lost = 1'b0;
    else if (accept_i && st_q.pending && !svc_start_i)
      st_d.lost = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign pending_o = st_q.pending;
  assign lost_o    = st_q.lost;

  // R4
  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !clr_cmd_i) |=> pending_o);

  // R5
  p_svc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_start_i && !accept_i) |=> !pending_o);

  // R6
  p_lost_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && pending_o && !svc_start_i && !clr_cmd_i && !lost_clr_i) |=> lost_o);

  // R7
  p_lost_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_clr_i || clr_cmd_i) |=> !lost_o);

  // R8
  p_clr_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd_i |=> !pending_o);
endmodule

// File: rtl/irq_cause_tracker.sv
module irq_cause_tracker #(
  parameter int unsigned N_EV = irq_trk_pkg::N_CAUSE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] evt_i,
  input  logic            cfg_first_i,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  input  logic            svc_start_i,
  input  logic            clr_cmd_i,
  input  logic            lost_clr_i,
  output logic [N_EV-1:0] cause_o,
  output logic            pending_o,
  output logic            lost_o,
  output logic            enable_o,
  output logic            irq_o
);
  logic [N_EV-1:0] grant;
  logic            any_evt;
  logic            accept;

  irq_cause_pick #(.N_EV(N_EV)) u_pick (
    .req_i   (evt_i),
    .grant_o (grant),
    .any_o   (any_evt)
  );

  irq_enable_reg u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_first_i (cfg_first_i),
    .en_set_i    (en_set_i),
    .en_clr_i    (en_clr_i),
    .enable_o    (enable_o)
  );

  // events count only against the enable value already in force
  assign accept = any_evt & enable_o;

  irq_cause_reg #(.N_EV(N_EV)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .grant_i (grant),
    .cause_o (cause_o)
  );

  irq_pend_lost u_pl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .svc_start_i (svc_start_i),
    .clr_cmd_i   (clr_cmd_i),
    .lost_clr_i  (lost_clr_i),
    .pending_o   (pending_o),
    .lost_o      (lost_o)
  );

  assign irq_o = pending_o & enable_o;

  // R3: the lowest-numbered event present is the recorded cause
  p_prio_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o && evt_i[0]) |=> cause_o[0]);

  // R10: disabled block ignores events
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_o && !svc_start_i && !clr_cmd_i && !lost_clr_i)
      |=> ($stable(cause_o) && $stable(pending_o) && $stable(lost_o)));
endmodule

// File: tb/test_irq_cause_tracker.sv
module test_irq_cause_tracker;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          cfg = 0, ens = 0, enc = 0, svc = 0, clr = 0, lclr = 0;
  logic [NE-1:0] cause;
  logic          pend, lost, en, irq;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  // behavioural reference state
  int m_cause = 0, m_pend = 0, m_lost = 0, m_en = 0;

  always #10 clk = ~clk;

  irq_cause_tracker #(.N_EV(NE)) i_irq_cause_tracker (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_first_i(cfg),
    .en_set_i(ens), .en_clr_i(enc), .svc_start_i(svc), .clr_cmd_i(clr),
    .lost_clr_i(lclr), .cause_o(cause), .pending_o(pend), .lost_o(lost),
    .enable_o(en), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = 0; m_pend = 0; m_lost = 0; m_en = 0;
    end else begin
      int acc, old_pend;
      acc = (m_en != 0 && evt != 0) ? 1 : 0;
      old_pend = m_pend;
      if (acc != 0) begin
        for (int i = NE - 1; i >= 0; i--)
          if (evt[i]) m_cause = 1 << i;
      end
      if (clr) m_pend = 0;
      else if (acc != 0) m_pend = 1;
      else if (svc) m_pend = 0;
      if (clr || lclr) m_lost = 0;
      else if (acc != 0 && old_pend != 0 && !svc) m_lost = 1;
      if (cfg || ens) m_en = 1;
      else if (enc) m_en = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2/R3 cause vs model", int'(cause), m_cause);
    chk("R4/R5/R8 pending vs model", int'(pend), m_pend);
    chk("R6/R7 lost vs model", int'(lost), m_lost);
    chk("R9 enable vs model", int'(en), m_en);
    chk("R11 irq vs model", int'(irq), (m_pend != 0 && m_en != 0) ? 1 : 0);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // drive at a falling edge, return after the next rising edge has acted
  task automatic drive(input logic [NE-1:0] e, input logic c, input logic s,
                       input logic d, input logic v, input logic k, input logic l);
    evt = e; cfg = c; ens = s; enc = d; svc = v; clr = k; lclr = l;
    @(negedge clk);
    evt = '0; cfg = 0; ens = 0; enc = 0; svc = 0; clr = 0; lclr = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cause", int'(cause), 0);
    chk("R1 reset pending", int'(pend), 0);
    chk("R1 reset enable", int'(en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release lost", int'(lost), 0);
    chk("R1 after release irq", int'(irq), 0);
    cmp_on = 1;

    drive(4'b0001, 0, 0, 0, 0, 0, 0);
    chk("R10 disabled cause", int'(cause), 0);
    chk("R10 disabled pending", int'(pend), 0);

    drive(4'b0000, 1, 0, 0, 0, 0, 0);
    chk("R9 first config enables", int'(en), 1);
    chk("R11 no irq without pending", int'(irq), 0);

    drive(4'b1100, 0, 0, 0, 0, 0, 0);
    chk("R3 high over low", int'(cause), 4);
    chk("R4 pending set", int'(pend), 1);
    chk("R11 irq raised", int'(irq), 1);
    chk("R6 no loss on first", int'(lost), 0);

    drive(4'b0010, 0, 0, 0, 0, 0, 0);
    chk("R2 cause replaced", int'(cause), 2);
    chk("R6 loss flagged", int'(lost), 1);

    drive(4'b0000, 0, 0, 0, 0, 0, 1);
    chk("R7 lost_clr clears", int'(lost), 0);
    chk("R7 lost_clr keeps pending", int'(pend), 1);

    drive(4'b0000, 0, 0, 0, 1, 0, 0);
    chk("R5 service clears pending", int'(pend), 0);

    drive(4'b1111, 0, 0, 0, 0, 0, 0);
    chk("R3 overflow highest", int'(cause), 1);

    drive(4'b1000, 0, 0, 0, 1, 0, 0);
    chk("R5 service with new event keeps pending", int'(pend), 1);
    chk("R6 service same cycle no loss", int'(lost), 0);
    chk("R2 low cause", int'(cause), 8);

    drive(4'b0100, 0, 0, 0, 0, 0, 0);
    chk("R6 loss again", int'(lost), 1);

    drive(4'b0001, 0, 0, 0, 0, 1, 0);
    chk("R8 clear beats event pending", int'(pend), 0);
    chk("R7 clear command drops lost", int'(lost), 0);
    chk("R8 cause still updates", int'(cause), 1);

    drive(4'b0010, 0, 0, 0, 0, 0, 0);
    drive(4'b0000, 0, 0, 1, 0, 0, 0);
    chk("R9 disable", int'(en), 0);
    chk("R11 irq masked while pending", int'(irq), 0);
    chk("R11 pending kept", int'(pend), 1);

    drive(4'b0100, 0, 0, 0, 0, 0, 0);
    chk("R10 cause unchanged", int'(cause), 2);
    chk("R10 lost unchanged", int'(lost), 0);

    drive(4'b0000, 0, 1, 1, 0, 0, 0);
    chk("R9 set wins over clear", int'(en), 1);
    chk("R11 irq returns", int'(irq), 1);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[3:0], r[4] & r[5] & r[6], r[7] & r[8], r[9] & r[10] & r[11],
            r[12] & r[13], r[14] & r[15] & r[16], r[17] & r[18] & r[19]);
    end

    cmp_on = 0;
    finish_run();
  end
endmodule